// File: doc/BRIEF.md
# Field-Linked Display Plane Descriptor Engine

This block sequences one graphics overlay plane from a chain of descriptors held in memory. Software places a descriptor address in the next-node pointer register. At each field sync the engine reads the sixteen-word descriptor found at that address. Once every word has arrived it swaps the words into its active shadow set in a single step. It then presents the decoded plane window, source address, pitch, clamped source size, pixel format and visibility to the downstream pixel fetcher and mixer.

Each descriptor carries its own next-node word, and the pointer register reloads from that word whenever a descriptor is applied. Two descriptors that point at each other therefore alternate on successive fields. Software can redirect the chain at any time by rewriting the pointer register. The new node is adopted at the following field sync, and never inside a field. A sticky status word reports buffer underflow and field syncs that arrived while a descriptor was still being fetched.

Top module: `plane_desc_engine`

## Requirements
- R1: After reset the plane is hidden, the source address, source size and format outputs are zero, the pointer register and the status word (byte offset 0x40) read zero, and no memory read is requested.
- R2: While the pointer register is zero, a field sync starts no memory read and the plane stays hidden.
- R3: A pointer value with any of its low four bits set is treated as invalid. A field sync then starts no memory read and leaves the active outputs unchanged.
- R4: On a field sync with a valid pointer P, the engine issues sixteen single-word reads at P, P+4, ... P+0x3C, one outstanding at a time. Descriptor word k sits at P+4k: word 0 control, 3 window start, 4 window end, 5 source address, 6 pitch, 7 size, 9 next pointer, 13 display-suppress, 2/8/12/14 reserved. The active outputs do not change until the sixteenth word has arrived.
- R5: When a descriptor is applied, the pointer register takes the value of its word 9. The field flag sampled at the applying sync is reported on `field_is_bot`, so two descriptors linked to each other alternate.
- R6: A software write to the pointer register (byte offset 0x24) leaves the active outputs untouched until the next field sync. If the write falls between the start of a fetch and the application of its descriptor, the written value is kept in preference to the descriptor's word 9.
- R7: If control bit 31 of a fetched descriptor is set, the descriptor is held after its fetch and applied only at the next field sync. That sync starts no new fetch.
- R8: `pix_fmt` equals control bits 4:0, and `alpha_full` equals control bit 5.
- R9: `in_window` is high exactly when the plane is shown and the pixel position lies inside the inclusive window. The window start word holds the first line in bits 31:16 and the first pixel in bits 15:0. The window end word holds the last line and the last pixel in the same layout.
- R10: The size word holds height in bits 31:16 and width in bits 15:0. `src_w` is the width clamped to 3840 and `src_h` is the height clamped to 2160.
- R11: If either bit 1 or bit 0 of the display-suppress word is set, `plane_show` and `in_window` are low, while descriptor sequencing continues.
- R12: An underflow input pulse sets status bit 0 and `underflow_flag`. The bit stays set until a read of the status word, which returns it as 1 and then clears it.
- R13: A field sync that arrives during a fetch sets status bit 1 and `missed_flag`, which are cleared by a status read. The running fetch completes without restarting.
- R14: A register read at byte offset 4k (k below 16) returns active descriptor word k one cycle after the read strobe. Offset 0x24 returns the pointer register, and reserved words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | Field sync, one-cycle pulse |
| field_bot | input | 1 | Field flag at sync: 1 bottom, 0 top |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | 32 | Byte address of requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_re |
| underflow | input | 1 | Buffer underflow pulse from pixel fetcher |
| pix_x | input | 16 | Current pixel position |
| pix_y | input | 16 | Current line position |
| plane_show | output | 1 | Plane is loaded and not suppressed |
| in_window | output | 1 | Current position inside the visible window |
| win_x0 | output | 16 | First pixel of window |
| win_y0 | output | 16 | First line of window |
| win_x1 | output | 16 | Last pixel of window |
| win_y1 | output | 16 | Last line of window |
| src_addr | output | 32 | Source pixel memory address |
| src_pitch | output | 32 | Source line pitch |
| src_w | output | 16 | Clamped source width |
| src_h | output | 16 | Clamped source height |
| pix_fmt | output | 5 | Pixel format code |
| alpha_full | output | 1 | Alpha range 0 to 255 selected |
| field_is_bot | output | 1 | Field of the applied descriptor |
| underflow_flag | output | 1 | Sticky underflow status |
| missed_flag | output | 1 | Sticky missed-field status |
| fetch_busy | output | 1 | Fetch in progress or descriptor held |

## Verification
The assertions assume that memory answers each read request with exactly one `mem_rvalid` pulse, and that no response arrives while no request is pending. They also assume that `vsync` and `underflow` are single-cycle pulses. The bench memory model latches one request at a time and answers it after a programmable latency. Field syncs, underflow pulses and register strobes are each driven for one cycle from the falling edge. Register reads and writes are never issued in the same cycle.

// File: rtl/pde_pkg.sv
package pde_pkg;
  localparam int DESC_WORDS    = 16;
  localparam int IDX_CTL       = 0;
  localparam int IDX_VPO       = 3;
  localparam int IDX_VPS       = 4;
  localparam int IDX_PML       = 5;
  localparam int IDX_PMP       = 6;
  localparam int IDX_SIZE      = 7;
  localparam int IDX_NVN       = 9;
  localparam int IDX_PPT       = 13;
  localparam int STAT_WORD     = 16;
  localparam int CTL_WAIT_BIT  = 31;
  localparam int CTL_ALPHA_BIT = 5;

  typedef logic [DESC_WORDS-1:0][31:0] desc_t;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT, F_HOLD} fetch_st_e;

  function automatic logic is_rsvd(input logic [5:0] w);
    return (w == 6'd2) || (w == 6'd8) || (w == 6'd12) || (w == 6'd14);
  endfunction
endpackage

// File: rtl/pde_fetch.sv
module pde_fetch
  import pde_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_i,
  input  logic              field_bot_i,
  input  logic [ADDR_W-1:0] nvn_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              busy_o,
  output logic              start_o,
  output logic              swap_o,
  output logic              swap_field_o,
  output logic              missed_o,
  output desc_t             stage_o
);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  fetch_st_e          st_q, st_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic               field_q, field_d;
  desc_t              stage_q;
  logic               nvn_ok, take_word;

  assign nvn_ok    = (nvn_i != '0) && (nvn_i[ALIGN_BITS-1:0] == '0);
  assign take_word = (st_q == F_WAIT) && mem_rvalid_i;

  // bypass the arriving word so the swap happens in the cycle of the last word
  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_view
    assign stage_o[g] = (take_word && idx_q == IDX_W'(g)) ? mem_rdata_i : stage_q[g];
  end

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    base_d  = base_q;
    field_d = field_q;
    start_o = 1'b0;
    swap_o  = 1'b0;
    missed_o = 1'b0;
    unique case (st_q)
      F_IDLE: begin
        if (vsync_i && nvn_ok) begin
          st_d    = F_REQ;
          idx_d   = '0;
          base_d  = nvn_i;
          field_d = field_bot_i;
          start_o = 1'b1;
        end
      end
      F_REQ: begin
        missed_o = vsync_i;
        st_d     = F_WAIT;
      end
      F_WAIT: begin
        missed_o = vsync_i;
        if (mem_rvalid_i) begin
          if (idx_q == LAST_IDX) begin
            if (stage_o[IDX_CTL][CTL_WAIT_BIT]) begin
              st_d = F_HOLD;
            end else begin
              st_d   = F_IDLE;
              swap_o = 1'b1;
            end
          end else begin
            idx_d = idx_q + 1'b1;
            st_d  = F_REQ;
          end
        end
      end
      F_HOLD: begin
        if (vsync_i) begin
          st_d    = F_IDLE;
          swap_o  = 1'b1;
          field_d = field_bot_i;
        end
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= F_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      field_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      base_q  <= base_d;
      field_q <= field_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (take_word) begin
      stage_q[idx_q] <= mem_rdata_i;
    end
  end

  assign mem_req_o    = (st_q == F_REQ);
  assign mem_addr_o   = base_q + ADDR_W'({idx_q, 2'b00});
  assign busy_o       = (st_q != F_IDLE);
  assign swap_field_o = (st_q == F_HOLD) ? field_bot_i : field_q;

  assert_single_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o);
  assert_bad_ptr_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && vsync_i && nvn_i[ALIGN_BITS-1:0] != '0) |=> !busy_o);
  assert_hold_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == F_HOLD) |-> !start_o);
endmodule

// File: rtl/pde_shadow.sv
module pde_shadow
  import pde_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int MAX_W   = 3840,
  parameter int MAX_H   = 2160
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               swap_i,
  input  logic               swap_field_i,
  input  desc_t              stage_i,
  input  logic [COORD_W-1:0] pix_x_i,
  input  logic [COORD_W-1:0] pix_y_i,
  output desc_t              words_o,
  output logic               plane_show_o,
  output logic               in_window_o,
  output logic [COORD_W-1:0] win_x0_o,
  output logic [COORD_W-1:0] win_y0_o,
  output logic [COORD_W-1:0] win_x1_o,
  output logic [COORD_W-1:0] win_y1_o,
  output logic [31:0]        src_addr_o,
  output logic [31:0]        src_pitch_o,
  output logic [15:0]        src_w_o,
  output logic [15:0]        src_h_o,
  output logic [4:0]         fmt_o,
  output logic               alpha_full_o,
  output logic               field_bot_o
);
  localparam logic [15:0] MAX_W_C = 16'(MAX_W);
  localparam logic [15:0] MAX_H_C = 16'(MAX_H);

  desc_t active_q;
  logic  loaded_q, field_q;
  logic  suppress;
  logic [15:0] w_raw, h_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      loaded_q <= 1'b0;
      field_q  <= 1'b0;
    end else if (swap_i) begin
      active_q <= stage_i;
      loaded_q <= 1'b1;
      field_q  <= swap_field_i;
    end
  end

  assign words_o      = active_q;
  assign suppress     = |active_q[IDX_PPT][1:0];
  assign plane_show_o = loaded_q && !suppress;
  assign win_x0_o     = active_q[IDX_VPO][COORD_W-1:0];
  assign win_y0_o     = active_q[IDX_VPO][16 +: COORD_W];
  assign win_x1_o     = active_q[IDX_VPS][COORD_W-1:0];
  assign win_y1_o     = active_q[IDX_VPS][16 +: COORD_W];
  assign src_addr_o   = active_q[IDX_PML];
  assign src_pitch_o  = active_q[IDX_PMP];
  assign fmt_o        = active_q[IDX_CTL][4:0];
  assign alpha_full_o = active_q[IDX_CTL][CTL_ALPHA_BIT];
  assign field_bot_o  = field_q;

  assign w_raw   = active_q[IDX_SIZE][15:0];
  assign h_raw   = active_q[IDX_SIZE][31:16];
  assign src_w_o = (w_raw > MAX_W_C) ? MAX_W_C : w_raw;
  assign src_h_o = (h_raw > MAX_H_C) ? MAX_H_C : h_raw;

  assign in_window_o = plane_show_o &&
                       (pix_x_i >= win_x0_o) && (pix_x_i <= win_x1_o) &&
                       (pix_y_i >= win_y0_o) && (pix_y_i <= win_y1_o);

  assert_outputs_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_i |=> $stable(src_addr_o) && $stable(fmt_o));
  assert_suppress_hides_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q[IDX_PPT][1:0] != 2'b00) |-> !in_window_o);
  assert_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_w_o <= MAX_W_C) && (src_h_o <= MAX_H_C));
endmodule

// File: rtl/pde_csr.sv
module pde_csr
  import pde_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  desc_t             words_i,
  input  logic [31:0]       desc_nvn_i,
  input  logic              start_i,
  input  logic              swap_i,
  input  logic              underflow_i,
  input  logic              missed_i,
  output logic [ADDR_W-1:0] nvn_o,
  output logic              uf_o,
  output logic              miss_o
);
  logic [ADDR_W-1:0] nvn_q, nvn_d;
  logic              dirty_q, dirty_d;
  logic              uf_q, uf_d, miss_q, miss_d;
  logic [31:0]       rd_q, rd_d;
  logic [5:0]        rd_idx;
  logic              we_nvn, rd_stat;

  assign rd_idx  = reg_addr_i[7:2];
  assign we_nvn  = reg_we_i && (rd_idx == 6'(IDX_NVN));
  assign rd_stat = reg_re_i && (rd_idx == 6'(STAT_WORD));

  always_comb begin
    nvn_d   = nvn_q;
    dirty_d = dirty_q;
    if (we_nvn) begin
      nvn_d   = reg_wdata_i[ADDR_W-1:0];
      dirty_d = 1'b1;
    end else begin
      if (swap_i && !dirty_q) nvn_d = desc_nvn_i[ADDR_W-1:0];
      if (start_i) dirty_d = 1'b0;
    end
    uf_d   = underflow_i | (uf_q & ~rd_stat);
    miss_d = missed_i | (miss_q & ~rd_stat);
  end

  always_comb begin
    rd_d = '0;
    if (rd_idx < 6'(DESC_WORDS)) begin
      if (rd_idx == 6'(IDX_NVN)) rd_d = 32'(nvn_q);
      else if (!is_rsvd(rd_idx)) rd_d = words_i[rd_idx[3:0]];
    end else if (rd_idx == 6'(STAT_WORD)) begin
      rd_d = {30'd0, miss_q, uf_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nvn_q   <= '0;
      dirty_q <= 1'b0;
      uf_q    <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      nvn_q   <= nvn_d;
      dirty_q <= dirty_d;
      uf_q    <= uf_d;
      miss_q  <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (reg_re_i) rd_q <= rd_d;
  end

  assign reg_rdata_o = rd_q;
  assign nvn_o       = nvn_q;
  assign uf_o        = uf_q;
  assign miss_o      = miss_q;

  assert_uf_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_i |=> uf_q);
  assert_uf_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !underflow_i) |=> !uf_q);
  assert_missed_set_R13: assert property (@(posedge clk) disable iff (!rst_n)
    missed_i |=> miss_q);
  assert_ptr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we_i && !swap_i) |=> $stable(nvn_q));
endmodule

// File: rtl/plane_desc_engine.sv
module plane_desc_engine
  import pde_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 16,
  parameter int MAX_W   = 3840,
  parameter int MAX_H   = 2160
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vsync,
  input  logic               field_bot,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_rvalid,
  input  logic [31:0]        mem_rdata,
  input  logic               reg_we,
  input  logic               reg_re,
  input  logic [7:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               underflow,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  output logic               plane_show,
  output logic               in_window,
  output logic [COORD_W-1:0] win_x0,
  output logic [COORD_W-1:0] win_y0,
  output logic [COORD_W-1:0] win_x1,
  output logic [COORD_W-1:0] win_y1,
  output logic [31:0]        src_addr,
  output logic [31:0]        src_pitch,
  output logic [15:0]        src_w,
  output logic [15:0]        src_h,
  output logic [4:0]         pix_fmt,
  output logic               alpha_full,
  output logic               field_is_bot,
  output logic               underflow_flag,
  output logic               missed_flag,
  output logic               fetch_busy
);
  logic [ADDR_W-1:0] nvn;
  logic              start, swap, swap_field, missed;
  desc_t             stage, words;

  pde_fetch #(.ADDR_W(ADDR_W), .ALIGN_BITS(4)) u_fetch (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .field_bot_i(field_bot),
    .nvn_i(nvn), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .busy_o(fetch_busy),
    .start_o(start), .swap_o(swap), .swap_field_o(swap_field),
    .missed_o(missed), .stage_o(stage)
  );

  pde_shadow #(.COORD_W(COORD_W), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_shadow (
    .clk(clk), .rst_n(rst_n), .swap_i(swap), .swap_field_i(swap_field),
    .stage_i(stage), .pix_x_i(pix_x), .pix_y_i(pix_y), .words_o(words),
    .plane_show_o(plane_show), .in_window_o(in_window),
    .win_x0_o(win_x0), .win_y0_o(win_y0), .win_x1_o(win_x1), .win_y1_o(win_y1),
    .src_addr_o(src_addr), .src_pitch_o(src_pitch), .src_w_o(src_w),
    .src_h_o(src_h), .fmt_o(pix_fmt), .alpha_full_o(alpha_full),
    .field_bot_o(field_is_bot)
  );

  pde_csr #(.ADDR_W(ADDR_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .words_i(words), .desc_nvn_i(stage[IDX_NVN]), .start_i(start),
    .swap_i(swap), .underflow_i(underflow), .missed_i(missed),
    .nvn_o(nvn), .uf_o(underflow_flag), .miss_o(missed_flag)
  );

  assert_no_fetch_zero_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_busy && nvn == '0) |=> !mem_req);
endmodule

// File: tb/test_plane_desc_engine.sv
module test_plane_desc_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vsync = 1'b0, field_bot = 1'b0;
  logic        mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        underflow = 1'b0;
  logic [15:0] pix_x = '0, pix_y = '0;
  logic        plane_show, in_window, alpha_full, field_is_bot;
  logic        underflow_flag, missed_flag, fetch_busy;
  logic [15:0] win_x0, win_y0, win_x1, win_y1, src_w, src_h;
  logic [31:0] src_addr, src_pitch;
  logic [4:0]  pix_fmt;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  plane_desc_engine i_plane_desc_engine (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .field_bot(field_bot),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .underflow(underflow), .pix_x(pix_x), .pix_y(pix_y),
    .plane_show(plane_show), .in_window(in_window), .win_x0(win_x0),
    .win_y0(win_y0), .win_x1(win_x1), .win_y1(win_y1), .src_addr(src_addr),
    .src_pitch(src_pitch), .src_w(src_w), .src_h(src_h), .pix_fmt(pix_fmt),
    .alpha_full(alpha_full), .field_is_bot(field_is_bot),
    .underflow_flag(underflow_flag), .missed_flag(missed_flag),
    .fetch_busy(fetch_busy)
  );

  // memory model: 64 words at 0x1000, one request at a time, programmable latency
  logic [31:0] memarr [64];
  logic [31:0] addr_log [1024];
  int          req_cnt = 0;
  int          lat_cyc = 0;
  logic        pend = 1'b0;
  int          cnt = 0;
  logic [31:0] pa = '0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      pend <= 1'b1;
      pa   <= mem_addr;
      cnt  <= lat_cyc;
      addr_log[req_cnt % 1024] <= mem_addr;
      req_cnt <= req_cnt + 1;
    end else if (pend) begin
      if (cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= memarr[pa[7:2]];
        pend       <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  typedef struct packed {
    logic [31:0] ctl;
    logic [31:0] size;
    logic [31:0] ppt;
    logic [15:0] ew;
    logic [15:0] eh;
    logic [4:0]  efmt;
    logic        ealpha;
    logic        eshow;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0025, 32'h0438_0780, 32'h0, 16'd1920, 16'd1080, 5'd5, 1'b1, 1'b1},
    '{32'h0000_0000, 32'h0870_0F00, 32'h0, 16'd3840, 16'd2160, 5'd0, 1'b0, 1'b1},
    '{32'h0000_0007, 32'h0BB8_1388, 32'h0, 16'd3840, 16'd2160, 5'd7, 1'b0, 1'b1},
    '{32'h0000_0006, 32'h000A_0014, 32'h1, 16'd20,   16'd10,   5'd6, 1'b0, 1'b0},
    '{32'h0000_0024, 32'h0871_0F01, 32'h2, 16'd3840, 16'd2160, 5'd4, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse_vsync(input logic bot);
    @(negedge clk);
    vsync = 1'b1; field_bot = bot;
    @(negedge clk);
    vsync = 1'b0;
  endtask

  task automatic put_desc(input int slot, input logic [31:0] ctl, input logic [31:0] vpo,
                          input logic [31:0] vps, input logic [31:0] pml,
                          input logic [31:0] size, input logic [31:0] nvn,
                          input logic [31:0] ppt);
    for (int i = 0; i < 16; i++) memarr[slot*16 + i] = 32'hDEAD_0000 + i;
    memarr[slot*16 + 0]  = ctl;
    memarr[slot*16 + 3]  = vpo;
    memarr[slot*16 + 4]  = vps;
    memarr[slot*16 + 5]  = pml;
    memarr[slot*16 + 6]  = 32'h0000_1E00;
    memarr[slot*16 + 7]  = size;
    memarr[slot*16 + 9]  = nvn;
    memarr[slot*16 + 13] = ppt;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int base;
    for (int i = 0; i < 64; i++) memarr[i] = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    chk("R1 plane_show", {31'd0, plane_show}, 32'd0);
    chk("R1 src_addr", src_addr, 32'd0);
    chk("R1 src_w", {16'd0, src_w}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    reg_read(8'h24, rd); chk("R1 pointer reg", rd, 32'd0);
    reg_read(8'h40, rd); chk("R1 status", rd, 32'd0);

    // R2 zero pointer: no fetch
    base = req_cnt;
    pulse_vsync(1'b0); wait_cyc(80);
    chk("R2 no reads", 32'(req_cnt - base), 32'd0);
    chk("R2 hidden", {31'd0, plane_show}, 32'd0);

    // R3 misaligned pointer ignored
    put_desc(0, 32'h25, 32'h0, 32'h0, 32'h5555_0000, 32'h0010_0010, 32'h1000, 32'h0);
    reg_write(8'h24, 32'h0000_1004);
    base = req_cnt;
    pulse_vsync(1'b0); wait_cyc(80);
    chk("R3 no reads", 32'(req_cnt - base), 32'd0);
    chk("R3 src unchanged", src_addr, 32'd0);
    chk("R3 hidden", {31'd0, plane_show}, 32'd0);

    // table walk: format, alpha, clamp, suppression
    for (int v = 0; v < NV; v++) begin
      put_desc(0, VECS[v].ctl, 32'h0, 32'h0, 32'h0010_0000 + v, VECS[v].size, 32'h1000, VECS[v].ppt);
      reg_write(8'h24, 32'h0000_1000);
      base = req_cnt;
      pulse_vsync(1'b0); wait_cyc(80);
      chk("R8 fmt", {27'd0, pix_fmt}, {27'd0, VECS[v].efmt});
      chk("R8 alpha", {31'd0, alpha_full}, {31'd0, VECS[v].ealpha});
      chk("R10 width", {16'd0, src_w}, {16'd0, VECS[v].ew});
      chk("R10 height", {16'd0, src_h}, {16'd0, VECS[v].eh});
      chk("R11 show", {31'd0, plane_show}, {31'd0, VECS[v].eshow});
      chk("R4 read count", 32'(req_cnt - base), 32'd16);
      chk("R4 first addr", addr_log[base % 1024], 32'h1000);
      chk("R4 last addr", addr_log[(base + 15) % 1024], 32'h103C);
      chk("R11 src applied", src_addr, 32'h0010_0000 + v);
    end

    // R14 register readback and R9 window decode
    put_desc(2, 32'h0, {16'd10, 16'd20}, {16'd30, 16'd40}, 32'h0000_7000, 32'h0010_0010, 32'h1080, 32'h0);
    reg_write(8'h24, 32'h0000_1080);
    pulse_vsync(1'b0); wait_cyc(80);
    reg_read(8'h0C, rd); chk("R14 start word", rd, {16'd10, 16'd20});
    reg_read(8'h14, rd); chk("R14 source word", rd, 32'h0000_7000);
    reg_read(8'h08, rd); chk("R14 reserved zero", rd, 32'd0);
    reg_read(8'h38, rd); chk("R14 reserved zero", rd, 32'd0);
    chk("R9 x0", {16'd0, win_x0}, 32'd20);
    chk("R9 y1", {16'd0, win_y1}, 32'd30);
    pix_x = 16'd20; pix_y = 16'd10; wait_cyc(1); chk("R9 first corner", {31'd0, in_window}, 32'd1);
    pix_x = 16'd40; pix_y = 16'd30; wait_cyc(1); chk("R9 last corner", {31'd0, in_window}, 32'd1);
    pix_x = 16'd19; pix_y = 16'd10; wait_cyc(1); chk("R9 left of", {31'd0, in_window}, 32'd0);
    pix_x = 16'd41; pix_y = 16'd30; wait_cyc(1); chk("R9 right of", {31'd0, in_window}, 32'd0);
    pix_x = 16'd20; pix_y = 16'd9;  wait_cyc(1); chk("R9 above", {31'd0, in_window}, 32'd0);
    pix_x = 16'd30; pix_y = 16'd31; wait_cyc(1); chk("R9 below", {31'd0, in_window}, 32'd0);
    pix_x = 16'd30; pix_y = 16'd20; wait_cyc(1); chk("R9 inside", {31'd0, in_window}, 32'd1);

    // R5 two linked descriptors alternate
    put_desc(0, 32'h0, 32'h0, 32'h0, 32'h0000_A000, 32'h0010_0010, 32'h1040, 32'h0);
    put_desc(1, 32'h0, 32'h0, 32'h0, 32'h0000_B000, 32'h0010_0010, 32'h1000, 32'h0);
    reg_write(8'h24, 32'h0000_1000);
    pulse_vsync(1'b0); wait_cyc(80);
    chk("R5 first A", src_addr, 32'h0000_A000);
    chk("R5 field top", {31'd0, field_is_bot}, 32'd0);
    reg_read(8'h24, rd); chk("R5 pointer reload", rd, 32'h1040);
    pulse_vsync(1'b1); wait_cyc(80);
    chk("R5 then B", src_addr, 32'h0000_B000);
    chk("R5 field bottom", {31'd0, field_is_bot}, 32'd1);
    reg_read(8'h24, rd); chk("R5 pointer reload", rd, 32'h1000);
    pulse_vsync(1'b0); wait_cyc(80);
    chk("R5 back to A", src_addr, 32'h0000_A000);

    // R6 software redirect taken only at next sync
    put_desc(2, 32'h0, 32'h0, 32'h0, 32'h0000_C000, 32'h0010_0010, 32'h1080, 32'h0);
    reg_write(8'h24, 32'h0000_1080);
    wait_cyc(20);
    chk("R6 no mid-field change", src_addr, 32'h0000_A000);
    pulse_vsync(1'b1); wait_cyc(80);
    chk("R6 redirect applied", src_addr, 32'h0000_C000);
    lat_cyc = 5;
    pulse_vsync(1'b0); wait_cyc(10);
    reg_write(8'h24, 32'h0000_1000);
    wait_cyc(200);
    reg_read(8'h24, rd); chk("R6 write during fetch wins", rd, 32'h1000);

    // R13 sync during fetch; R4 no change mid-fetch
    base = req_cnt;
    pulse_vsync(1'b0); wait_cyc(20);
    chk("R4 unchanged mid-fetch", src_addr, 32'h0000_C000);
    pulse_vsync(1'b1); wait_cyc(200);
    chk("R13 flag", {31'd0, missed_flag}, 32'd1);
    chk("R13 no restart", 32'(req_cnt - base), 32'd16);
    chk("R13 fetch completes", src_addr, 32'h0000_A000);
    reg_read(8'h40, rd); chk("R13 status bit1", rd, 32'h2);
    reg_read(8'h40, rd); chk("R13 cleared by read", rd, 32'h0);
    lat_cyc = 0;

    // R7 wait-for-sync descriptor
    put_desc(3, 32'h8000_0000, 32'h0, 32'h0, 32'h0000_D000, 32'h0010_0010, 32'h10C0, 32'h0);
    reg_write(8'h24, 32'h0000_10C0);
    pulse_vsync(1'b0); wait_cyc(80);
    chk("R7 held not applied", src_addr, 32'h0000_A000);
    chk("R7 busy while held", {31'd0, fetch_busy}, 32'd1);
    base = req_cnt;
    pulse_vsync(1'b1); wait_cyc(2);
    chk("R7 applied at sync", src_addr, 32'h0000_D000);
    chk("R7 field of applying sync", {31'd0, field_is_bot}, 32'd1);
    wait_cyc(10);
    chk("R7 no new fetch", 32'(req_cnt - base), 32'd0);

    // R12 underflow sticky until read
    @(negedge clk); underflow = 1'b1;
    @(negedge clk); underflow = 1'b0;
    wait_cyc(3);
    chk("R12 flag set", {31'd0, underflow_flag}, 32'd1);
    reg_read(8'h40, rd); chk("R12 status bit0", rd, 32'h1);
    chk("R12 flag cleared", {31'd0, underflow_flag}, 32'd0);
    reg_read(8'h40, rd); chk("R12 read after clear", rd, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule